// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the event flags and the interrupt-enable mask of a bus-master serial controller. It turns them into one level-sensitive interrupt and two DMA request lines. The transfer logic raises a flag by pulsing the matching bit of `evt_set`. Software reaches four registers through a single-cycle read/write port. A read is combinational: `reg_rdata` reflects the addressed register while `reg_rd` is high and is zero otherwise.

The register word at each address is:

| Address | Register |
|---|---|
| 0 | interrupt enable |
| 1 | flag (status) |
| 2 | vector |
| 3 | DMA steering |

Flag bit 3 means receive-ready, bit 4 means transmit-ready, and bit 12 reads as the bus-busy indication.

The parameter `NEWER_MAP` selects one of two register layouts.

- **Older layout (`NEWER_MAP=0`)**: flags are cleared only by reading the vector register. That read reports the one-based position of the lowest flag that is both set and enabled, and retires that flag in the same access.
- **Newer layout (`NEWER_MAP=1`)**: the vector register reads zero, and software clears selected flags by writing ones to the flag register.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset all flags, the enable mask and both DMA steering bits are zero, and `irq`, `drq_rx` and `drq_tx` are low.
- R2: `irq` is high in exactly those cycles where the stored flags AND the stored enable mask is nonzero. It depends on register state only.
- R3: A one on `evt_set[i]` sets flag i at the next clock edge, and the flag stays set until it is cleared.
- R4: Reading address 1 returns the stored flags, with bit 12 replaced by the current value of `bus_busy`.
- R5: A write to address 0 stores `wdata[5:0]` ANDed with 0x1f in the older layout, or with 0x3f in the newer layout. Reading address 0 returns the mask, zero-extended.
- R6: In the older layout, a read of address 2 returns n+1, where n is the lowest bit position set in (flags AND enable). It returns 0 when no such bit is set. At the next edge that single flag n is cleared.
- R7: In the older layout, writes to address 1 leave the flags unchanged. In the newer layout, a write to address 1 clears the flags under (`wdata` AND 0x0027), and a read of address 2 returns 0 and clears nothing.
- R8: A write to address 3 stores only `wdata[15]` (receive DMA enable) and `wdata[7]` (transmit DMA enable). Reading address 3 returns those two bits in the same positions and zero elsewhere.
- R9: A write to address 3 with bit 15 set clears enable bit 3. A write with bit 7 set clears enable bit 4.
- R10: `drq_rx` equals (receive DMA enable AND flag 3) and `drq_tx` equals (transmit DMA enable AND flag 4), both as they stood one clock earlier.
- R11: When a set pulse and a software clear (vector acknowledge or write-one-to-clear) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select (0 enable, 1 flags, 2 vector, 3 DMA steering) |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_rd | input | 1 | Read strobe; also qualifies the vector acknowledge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational, zero when not reading |
| evt_set | input | 16 | Per-flag set pulses from the transfer logic |
| bus_busy | input | 1 | Live bus-busy indication, shown as flag bit 12 |
| irq | output | 1 | Level interrupt request |
| drq_rx | output | 1 | Registered receive DMA request |
| drq_tx | output | 1 | Registered transmit DMA request |

## Verification
A set pulse from the transfer logic and a software clear can strike the same flag in one cycle. The clear comes from the vector acknowledge in the older layout and from write-one-to-clear in the newer one.

The bench provokes this directly: it acknowledges a pending vector while pulsing that flag, and it writes ones over a flag while pulsing it. It then reads the flags back and expects the bit to still be set.

The random phase drives both layouts side by side from shared inputs. It mixes event pulses with reads and writes on every cycle, so a DMA steering write also lands together with ready-flag changes. The bench judges every read, `irq` and the DMA requests against a cycle model kept in the bench.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_FLAGS  = 2'd1,
        RA_VECTOR = 2'd2,
        RA_DMACFG = 2'd3
    } reg_sel_e;

    localparam int RX_RDY_BIT = 3;
    localparam int TX_RDY_BIT = 4;
    localparam int BUSY_BIT   = 12;
    localparam int RX_DMA_BIT = 15;
    localparam int TX_DMA_BIT = 7;

endpackage

// File: rtl/irq_vec_prienc.sv
module irq_vec_prienc #(
    parameter int W = 16,
    localparam int IDX_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     pick
);
    always_comb begin
        idx  = '0;
        pick = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx     = IDX_W'(i + 1);
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_vec_dma.sv
module irq_vec_dma
    import irq_vec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] wdata,
    input  logic         rx_rdy,
    input  logic         tx_rdy,
    output logic         rx_en,
    output logic         tx_en,
    output logic         drq_rx,
    output logic         drq_tx
);
    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic drq_rx;
        logic drq_tx;
    } dma_st_t;

    dma_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.rx_en = wdata[RX_DMA_BIT];
            st_d.tx_en = wdata[TX_DMA_BIT];
        end
        st_d.drq_rx = st_q.rx_en & rx_rdy;
        st_d.drq_tx = st_q.tx_en & tx_rdy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_en  = st_q.rx_en;
    assign tx_en  = st_q.tx_en;
    assign drq_rx = st_q.drq_rx;
    assign drq_tx = st_q.drq_tx;

    // R10: a request only follows an enabled, ready source one cycle back
    p_drq_rx_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drq_rx |-> $past(rx_en && rx_rdy));
    p_drq_rx_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_rdy) |=> drq_rx);
    p_drq_tx_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drq_tx |-> $past(tx_en && tx_rdy));
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
    import irq_vec_pkg::*;
#(
    parameter bit              NEWER_MAP = 1'b0,
    parameter int              REG_W     = 16,
    parameter int              EN_W      = 6,
    parameter logic [REG_W-1:0] W1C_MASK = 16'h0027,
    localparam int             IDX_W     = $clog2(REG_W + 1),
    localparam logic [EN_W-1:0] EN_MASK  = NEWER_MAP ? {EN_W{1'b1}}
                                                     : {1'b0, {(EN_W-1){1'b1}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [REG_W-1:0] evt_set,
    input  logic             bus_busy,
    output logic             irq,
    output logic             drq_rx,
    output logic             drq_tx
);
    typedef struct packed {
        logic [REG_W-1:0] flags;
        logic [EN_W-1:0]  en;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic             en_wr, flg_wr, dma_wr, vec_ack;
    logic [REG_W-1:0] pend, vec_pick, clr, flags_view;
    logic [IDX_W-1:0] vec_idx;
    logic             rx_dma_en, tx_dma_en;

    assign en_wr   = reg_wr && (reg_addr == RA_ENABLE);
    assign flg_wr  = reg_wr && (reg_addr == RA_FLAGS);
    assign dma_wr  = reg_wr && (reg_addr == RA_DMACFG);
    assign vec_ack = !NEWER_MAP && reg_rd && (reg_addr == RA_VECTOR);

    assign pend = st_q.flags & {{(REG_W-EN_W){1'b0}}, st_q.en};

    irq_vec_prienc #(.W(REG_W)) u_pick (
        .req  (pend),
        .idx  (vec_idx),
        .pick (vec_pick)
    );

    irq_vec_dma #(.W(REG_W)) u_dma (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (dma_wr),
        .wdata  (reg_wdata),
        .rx_rdy (st_q.flags[RX_RDY_BIT]),
        .tx_rdy (st_q.flags[TX_RDY_BIT]),
        .rx_en  (rx_dma_en),
        .tx_en  (tx_dma_en),
        .drq_rx (drq_rx),
        .drq_tx (drq_tx)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (vec_ack)
            clr = clr | vec_pick;
        if (NEWER_MAP && flg_wr)
            clr = clr | (reg_wdata & W1C_MASK);
        st_d.flags = (st_q.flags & ~clr) | evt_set;
        if (en_wr)
            st_d.en = reg_wdata[EN_W-1:0] & EN_MASK;
        if (dma_wr) begin
            if (reg_wdata[RX_DMA_BIT]) st_d.en[RX_RDY_BIT] = 1'b0;
            if (reg_wdata[TX_DMA_BIT]) st_d.en[TX_RDY_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags_view           = st_q.flags;
        flags_view[BUSY_BIT] = bus_busy;
        reg_rdata            = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                RA_ENABLE: reg_rdata = {{(REG_W-EN_W){1'b0}}, st_q.en};
                RA_FLAGS:  reg_rdata = flags_view;
                RA_VECTOR: reg_rdata = NEWER_MAP ? '0 : REG_W'(vec_idx);
                default: begin
                    reg_rdata[RX_DMA_BIT] = rx_dma_en;
                    reg_rdata[TX_DMA_BIT] = tx_dma_en;
                end
            endcase
        end
    end

    assign irq = |pend;

    // R3: every pulsed flag is set after the edge
    p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((st_q.flags & $past(evt_set)) == $past(evt_set)));
    // R6: the reported source is the lowest pending one
    p_vec_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && vec_idx != '0) |-> ($countones(vec_pick) == 1
            && |(vec_pick & pend) && (((vec_pick - 1'b1) & pend) == '0)));
    // R6: the acknowledged flag is gone after the edge unless re-pulsed
    p_vec_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && |vec_pick && !(|(vec_pick & evt_set)))
            |=> !(|(st_q.flags & $past(vec_pick))));
    // R11: a set pulse beats a same-cycle acknowledge
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && |(vec_pick & evt_set))
            |=> |(st_q.flags & $past(vec_pick)));
    // R7: flags never drop on a write in the older layout
    p_flags_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!NEWER_MAP && flg_wr && !vec_ack)
            |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));
    // R9: DMA steering takes its direction out of the enable mask
    p_dma_mask_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && reg_wdata[RX_DMA_BIT] && !en_wr) |=> !st_q.en[RX_RDY_BIT]);
    p_dma_mask_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && reg_wdata[TX_DMA_BIT] && !en_wr) |=> !st_q.en[TX_RDY_BIT]);
endmodule

// File: tb/irq_vec_unit_test.sv
module irq_vec_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0, busy = 1'b0;
    logic [15:0] wdata = '0, evt = '0;
    logic [15:0] rdata_o, rdata_n;
    logic        irq_o, irq_n, drqr_o, drqr_n, drqt_o, drqt_n;

    int total = 0;
    int bad = 0;

    logic [15:0] m_flags [2];
    logic [5:0]  m_en    [2];
    logic        m_rxe [2], m_txe [2], m_drqr [2], m_drqt [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_unit #(.NEWER_MAP(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata_o), .evt_set(evt), .bus_busy(busy),
        .irq(irq_o), .drq_rx(drqr_o), .drq_tx(drqt_o));

    irq_vec_unit #(.NEWER_MAP(1'b1)) uut_n (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata_n), .evt_set(evt), .bus_busy(busy),
        .irq(irq_n), .drq_rx(drqr_n), .drq_tx(drqt_n));

    task automatic chk(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic int lowest(input logic [15:0] v);
        for (int i = 0; i < 16; i++)
            if (v[i]) return i + 1;
        return 0;
    endfunction

    function automatic logic [15:0] exp_rd(input int m, input logic [1:0] a,
                                           input logic b);
        logic [15:0] v;
        case (a)
            2'd0: v = {10'b0, m_en[m]};
            2'd1: begin v = m_flags[m]; v[12] = b; end
            2'd2: v = (m == 0) ? 16'(lowest(m_flags[m] & {10'b0, m_en[m]})) : 16'h0;
            default: begin v = '0; v[15] = m_rxe[m]; v[7] = m_txe[m]; end
        endcase
        return v;
    endfunction

    task automatic step(input logic [1:0] a, input logic w, input logic r,
                        input logic [15:0] d, input logic [15:0] e,
                        input logic b, input string tag);
        @(negedge clk);
        addr = a; wr = w; rd = r; wdata = d; evt = e; busy = b;
        #1;
        for (int m = 0; m < 2; m++) begin
            string t;
            logic [15:0] pend, clr;
            logic nr, nt;
            int idx;
            chk("R10", "drq_rx", 16'(m == 0 ? drqr_o : drqr_n), 16'(m_drqr[m]));
            chk("R10", "drq_tx", 16'(m == 0 ? drqt_o : drqt_n), 16'(m_drqt[m]));
            pend = m_flags[m] & {10'b0, m_en[m]};
            chk("R2", "irq", 16'(m == 0 ? irq_o : irq_n), 16'(|pend));
            if (r) begin
                case (a)
                    2'd0: t = "R5";
                    2'd1: t = "R4";
                    2'd2: t = (m == 0) ? "R6" : "R7";
                    default: t = "R8";
                endcase
                if (tag != "") t = tag;
                chk(t, (m == 0) ? "rdata older" : "rdata newer",
                    (m == 0) ? rdata_o : rdata_n, exp_rd(m, a, b));
            end
            idx = lowest(pend);
            clr = '0;
            if (m == 0 && r && a == 2'd2 && idx != 0) clr[idx-1] = 1'b1;
            if (m == 1 && w && a == 2'd1) clr = clr | (d & 16'h0027);
            nr = m_rxe[m] & m_flags[m][3];
            nt = m_txe[m] & m_flags[m][4];
            m_flags[m] = (m_flags[m] & ~clr) | e;
            if (w && a == 2'd0) m_en[m] = d[5:0] & ((m == 0) ? 6'h1f : 6'h3f);
            if (w && a == 2'd3) begin
                m_rxe[m] = d[15];
                m_txe[m] = d[7];
                if (d[15]) m_en[m][3] = 1'b0;
                if (d[7])  m_en[m][4] = 1'b0;
            end
            m_drqr[m] = nr;
            m_drqt[m] = nt;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int m = 0; m < 2; m++) begin
            m_flags[m] = '0; m_en[m] = '0; m_rxe[m] = 1'b0; m_txe[m] = 1'b0;
            m_drqr[m] = 1'b0; m_drqt[m] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs after reset
        chk("R1", "irq older", 16'(irq_o), 16'h0);
        chk("R1", "irq newer", 16'(irq_n), 16'h0);
        chk("R1", "drq older", 16'({drqr_o, drqt_o}), 16'h0);
        chk("R1", "drq newer", 16'({drqr_n, drqt_n}), 16'h0);
        step(2'd0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R1");
        step(2'd1, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R1");
        step(2'd3, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R1");

        // R5: mask width per layout
        step(2'd0, 1'b1, 1'b0, 16'hffff, 16'h0, 1'b0, "");
        step(2'd0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R5");

        // R3 and R4: pulsed flags persist, bit 12 shows live busy
        step(2'd0, 1'b0, 1'b0, 16'h0, 16'h0032, 1'b0, "");
        step(2'd1, 1'b0, 1'b1, 16'h0, 16'h0, 1'b1, "R3");
        step(2'd1, 1'b0, 1'b1, 16'h0, 16'h1000, 1'b0, "R4");
        step(2'd1, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R4");

        // R6: vector walks upward through pending enabled flags
        step(2'd2, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R6");
        step(2'd2, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R6");
        step(2'd2, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R6");
        step(2'd1, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R6");

        // R11: acknowledge and write-one-to-clear racing a set pulse
        step(2'd0, 1'b0, 1'b0, 16'h0, 16'h0004, 1'b0, "");
        step(2'd2, 1'b0, 1'b1, 16'h0, 16'h0004, 1'b0, "R11");
        step(2'd1, 1'b1, 1'b0, 16'h0004, 16'h0004, 1'b0, "");
        step(2'd1, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R11");

        // R7: flag writes per layout
        step(2'd0, 1'b0, 1'b0, 16'h0, 16'h00ff, 1'b0, "");
        step(2'd1, 1'b1, 1'b0, 16'hffff, 16'h0, 1'b0, "");
        step(2'd1, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R7");
        step(2'd2, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R7");

        // R8, R9, R10: DMA steering
        step(2'd0, 1'b1, 1'b0, 16'h003f, 16'h0, 1'b0, "");
        step(2'd3, 1'b1, 1'b0, 16'hffff, 16'h0018, 1'b0, "");
        step(2'd3, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R8");
        step(2'd0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, "R9");
        step(2'd1, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, "R10");
        step(2'd3, 1'b1, 1'b0, 16'h0080, 16'h0, 1'b0, "");
        step(2'd1, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, "R10");
        step(2'd1, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, "R10");

        // random mix, both layouts against the model
        for (int n = 0; n < 4000; n++) begin
            logic [1:0]  ra;
            logic        rw, rr, rb;
            logic [15:0] rdat, re;
            ra   = 2'($urandom);
            rw   = ($urandom % 3) == 0;
            rr   = ($urandom % 2) == 0;
            rdat = 16'($urandom);
            re   = (($urandom % 4) == 0) ? (16'($urandom) & 16'h10ff) : 16'h0;
            rb   = 1'($urandom);
            step(ra, rw, rr, rdat, re, rb, "");
        end
        step(2'd0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, "");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule